// File: doc/BRIEF.md
# Keyed Watchdog Timer with Toggle-Code Refresh

This block is a watchdog timer driven through a small 32-bit register file. Every write has to carry a fixed 16-bit key in its upper half-word; a write with any other upper half is discarded. The lower half-word is the payload.

Four registers are mapped:

| Offset | Content |
|---|---|
| 0x04 | configuration: prescaler divisor field in bits 15:8 |
| 0x08 | 16-bit reload value |
| 0x18 | refresh groups |
| 0x1C | run control: bit 0 enables counting |

The refresh register does not take a single kick value. It holds three two-bit groups, and each group alternates between the codes 1 and 2. A group's action fires when a keyed write flips that group's code to the other valid value. Software kicks the timer by reading the refresh register, inverting its low six bits and writing the result back with the key, which fires all three actions at once.

A prescaler derives a count tick from the timer clock, which is nominally 32768 Hz. The tick steps a 16-bit down-counter. When the counter reaches zero while counting is enabled, a registered reset request rises and stays high until the block itself is reset. A warning interrupt rises when the counter passes half of the value it was last reloaded with. The register interface is a plain single-cycle write strobe and a combinational read port, with no handshake.

Top module: `wdg_keyed_timer`

## Requirements
- R1: A write is accepted only when `wr_data[31:16]` equals 16'h1234. Any other write leaves every register unchanged.
- R2: After reset the registers read as follows: configuration 0x00000F00 (divide by 16), reload 0x0000FFFF, refresh 0x00000015 (every group at code 1), run control 0. Both `rst_req_o` and `irq_o` are low.
- R3: The configuration, reload and run-control registers read back the full 16-bit payload of the last accepted write, with bits 31:16 read as zero.
- R4: The refresh groups sit at bits 5:4 (commit divisor), bits 3:2 (reload counter) and bits 1:0 (clear interrupt). Writing the other valid code (1 or 2) over a group fires its action and stores the new code. Writing code 0 or 3 leaves the stored code unchanged and fires nothing. Writing the same code also fires nothing.
- R5: A reload action loads the counter from the reload register and restarts the prescaler. A reload before zero postpones expiry to a full period after the reload.
- R6: The prescaler uses a committed divisor field d and ticks once every d+1 clocks. Writing the configuration register alone does not change the committed value; only a commit action copies bits 15:8 into it.
- R7: Run-control bit 0 enables counting. While it is clear the counter holds its value and resumes from that value when it is set again.
- R8: Counting is enabled at clock edge E0 with count N and committed field d. The counter reaches zero at edge E0+N*(d+1), and `rst_req_o` rises one edge later. `rst_req_o` then stays high until reset, even if counting is stopped.
- R9: `irq_o` rises on the edge where the counter steps to floor(R/2), where R is the last reloaded value. It is cleared on the edge of a clear-interrupt action.
- R10: A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data: key in 31:16, payload in 15:0 |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data, upper half zero |
| rst_req_o | output | 1 | Sticky registered reset request on expiry |
| irq_o | output | 1 | Half-period warning interrupt |

## Verification
The counter is not visible at the ports, so a wrong count, a wrong divisor or a missed reload only shows up when `rst_req_o` or `irq_o` rises on the wrong edge. For that reason the bench checks each expiry on the exact edge before and the exact edge after it. A refresh group stored with a bad code, or one that fires on a write it should ignore, shows up at the next read of the refresh register, or as an expiry that has moved in time. A key gate that lets a bad write through is caught by reading the targeted register back on the following cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int          ADDR_W   = 8;
  localparam int          DATA_W   = 32;
  localparam int          PAY_W    = 16;
  localparam logic [15:0] WR_KEY   = 16'h1234;
  localparam logic [7:0]  OFS_CFG  = 8'h04;
  localparam logic [7:0]  OFS_LOAD = 8'h08;
  localparam logic [7:0]  OFS_KICK = 8'h18;
  localparam logic [7:0]  OFS_RUN  = 8'h1C;
  localparam int          NGRP     = 3;
  localparam logic [1:0]  CODE_A   = 2'd1;
  localparam logic [1:0]  CODE_B   = 2'd2;
  // group index order matches bit position: 0 -> 1:0, 1 -> 3:2, 2 -> 5:4
  localparam int          G_IRQ    = 0;
  localparam int          G_RELOAD = 1;
  localparam int          G_COMMIT = 2;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 8'd15,
  parameter logic [CNT_W-1:0] LOAD_RST = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DIV_W-1:0]  div_field,
  output logic [CNT_W-1:0]  load_val,
  output logic              run_en,
  output logic [NGRP-1:0]   fire
);
  localparam int GRP_BITS = 2 * NGRP;
  localparam int DIV_LSB  = PAY_W - DIV_W;

  logic [PAY_W-1:0]    cfg_q, run_q;
  logic [CNT_W-1:0]    load_q;
  logic [GRP_BITS-1:0] grp_q, grp_d;
  logic                wr_ok;
  logic [PAY_W-1:0]    pay;

  assign wr_ok = wr_en && (wr_data[DATA_W-1:PAY_W] == WR_KEY);
  assign pay   = wr_data[PAY_W-1:0];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [1:0] cur, nxt;
    logic       nxt_ok, hit;
    assign cur    = grp_q[2*g +: 2];
    assign nxt    = pay[2*g +: 2];
    assign nxt_ok = (nxt == CODE_A) || (nxt == CODE_B);
    assign hit    = wr_ok && (wr_addr == OFS_KICK) && nxt_ok;
    assign grp_d[2*g +: 2] = hit ? nxt : cur;
    assign fire[g] = hit && (nxt != cur);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= PAY_W'({DIV_RST, {DIV_LSB{1'b0}}});
      load_q <= LOAD_RST;
      run_q  <= '0;
      grp_q  <= {NGRP{CODE_A}};
    end else begin
      grp_q <= grp_d;
      if (wr_ok) begin
        case (wr_addr)
          OFS_CFG:  cfg_q  <= pay;
          OFS_LOAD: load_q <= pay[CNT_W-1:0];
          OFS_RUN:  run_q  <= pay;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_CFG:  rd_data[PAY_W-1:0]    = cfg_q;
      OFS_LOAD: rd_data[CNT_W-1:0]    = load_q;
      OFS_KICK: rd_data[GRP_BITS-1:0] = grp_q;
      OFS_RUN:  rd_data[PAY_W-1:0]    = run_q;
      default:  rd_data = '0;
    endcase
  end

  assign div_field = cfg_q[PAY_W-1:DIV_LSB];
  assign load_val  = load_q;
  assign run_en    = run_q[0];

  a_r1_bad_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DATA_W-1:PAY_W] != WR_KEY) |=>
      ($stable(cfg_q) && $stable(load_q) && $stable(run_q) && $stable(grp_q)));

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    a_r4_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_q[2*g +: 2] == CODE_A) || (grp_q[2*g +: 2] == CODE_B));
    a_r4_fire_flips: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |=> (grp_q[2*g +: 2] != $past(grp_q[2*g +: 2])));
  end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 8'd15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             commit,
  input  logic [DIV_W-1:0] div_field,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, pre_q;

  assign tick = en && !restart && (pre_q >= div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_RST;
      pre_q <= '0;
    end else begin
      if (commit) div_q <= div_field;
      if (!en || restart || pre_q >= div_q) pre_q <= '0;
      else                                  pre_q <= pre_q + 1'b1;
    end
  end

  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != '0 && !commit) |=> !tick);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  input  logic             irq_clr,
  output logic             rst_req,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q, rel_q;
  logic             warn_hit;

  assign warn_hit = tick && !reload && (cnt_q != '0) &&
                    ((cnt_q - 1'b1) == (rel_q >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= LOAD_RST;
      rel_q   <= LOAD_RST;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (reload) begin
        cnt_q <= load_val;
        rel_q <= load_val;
      end else if (tick && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      rst_req <= rst_req || (run_en && cnt_q == '0);
      irq     <= warn_hit || (irq && !irq_clr);
    end
  end

  a_r8_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  a_r8_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(run_en && cnt_q == '0));
  a_r7_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !reload) |=> $stable(cnt_q));
  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(load_val)));
  a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !warn_hit) |=> !irq);
endmodule

// File: rtl/wdg_keyed_timer.sv
module wdg_keyed_timer
  import wdg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 8'd15,
  parameter logic [CNT_W-1:0] LOAD_RST = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        rst_req_o,
  output logic        irq_o
);
  logic [DIV_W-1:0] div_field;
  logic [CNT_W-1:0] load_val;
  logic             run_en, tick;
  logic [NGRP-1:0]  fire;

  wdg_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST), .LOAD_RST(LOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .div_field(div_field), .load_val(load_val),
    .run_en(run_en), .fire(fire));

  wdg_prescaler #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(run_en), .restart(fire[G_RELOAD]),
    .commit(fire[G_COMMIT]), .div_field(div_field), .tick(tick));

  wdg_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .reload(fire[G_RELOAD]),
    .load_val(load_val), .irq_clr(fire[G_IRQ]), .rst_req(rst_req_o), .irq(irq_o));
endmodule

// File: tb/wdg_keyed_timer_tb.sv
module wdg_keyed_timer_tb;
  localparam int CLK_P = 8;
  localparam int Q = CLK_P / 4;
  localparam int LIMIT = 200000;
  localparam logic [15:0] KEY = 16'h1234;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic rst_req_o, irq_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wdg_keyed_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_req_o(rst_req_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #Q rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] k, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = {k, d};
    @(posedge clk);
    #Q wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #Q;
  endtask

  task automatic arm(input logic [15:0] load, input logic [7:0] dfield);
    wr(8'h08, KEY, load);
    wr(8'h04, KEY, {dfield, 8'h00});
    wr(8'h18, KEY, 16'h002A);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(8'h04, v); chk("R2 cfg", v, 32'h0F00);
    rd(8'h08, v); chk("R2 load", v, 32'hFFFF);
    rd(8'h18, v); chk("R2 refresh", v, 32'h15);
    rd(8'h1C, v); chk("R2 run", v, 32'h0);
    chk("R2 rst_req", {31'b0, rst_req_o}, 0);
    chk("R2 irq", {31'b0, irq_o}, 0);
    rd(8'h0C, v); chk("R10 unmapped", v, 0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    do_reset();
    wr(8'h04, 16'h1235, 16'h1111);
    rd(8'h04, v); chk("R1 bad key cfg", v, 32'h0F00);
    wr(8'h18, 16'h0000, 16'h002A);
    rd(8'h18, v); chk("R1 bad key refresh", v, 32'h15);
    wr(8'h04, KEY, 16'hBEEF);
    rd(8'h04, v); chk("R3 cfg readback", v, 32'h0000BEEF);
    wr(8'h1C, KEY, 16'hA5A0);
    rd(8'h1C, v); chk("R3 run readback", v, 32'h0000A5A0);
    wr(8'h08, KEY, 16'h0123);
    rd(8'h08, v); chk("R3 load readback", v, 32'h00000123);
  endtask

  task automatic t_codes();
    logic [31:0] v;
    do_reset();
    wr(8'h18, KEY, 16'h003F);
    rd(8'h18, v); chk("R4 code3 ignored", v, 32'h15);
    wr(8'h18, KEY, 16'h0000);
    rd(8'h18, v); chk("R4 code0 ignored", v, 32'h15);
    wr(8'h18, KEY, 16'h0016);
    rd(8'h18, v); chk("R4 single group flip", v, 32'h16);
    rd(8'h18, v);
    wr(8'h18, KEY, (v[15:0] ^ 16'h003F));
    rd(8'h18, v); chk("R4 inverted write", v, 32'h29);
  endtask

  task automatic t_expiry();
    do_reset();
    arm(16'd6, 8'd2);
    wr(8'h1C, KEY, 16'h0001);
    wait_edges(8);  chk("R9 irq before half", {31'b0, irq_o}, 0);
    wait_edges(1);  chk("R9 irq at half", {31'b0, irq_o}, 1);
    wait_edges(9);  chk("R8 no req at zero edge", {31'b0, rst_req_o}, 0);
    wait_edges(1);  chk("R8 req one edge later", {31'b0, rst_req_o}, 1);
    wr(8'h1C, KEY, 16'h0000);
    wait_edges(3);  chk("R8 req sticky", {31'b0, rst_req_o}, 1);
  endtask

  task automatic t_reload();
    do_reset();
    arm(16'd4, 8'd0);
    wr(8'h1C, KEY, 16'h0001);
    wait_edges(2);
    wr(8'h18, KEY, 16'h0026);
    wait_edges(2);  chk("R5 original expiry skipped", {31'b0, rst_req_o}, 0);
    wait_edges(2);  chk("R5 before new expiry", {31'b0, rst_req_o}, 0);
    wait_edges(1);  chk("R5 expiry after reload", {31'b0, rst_req_o}, 1);
  endtask

  task automatic t_commit();
    logic [31:0] v;
    do_reset();
    arm(16'd4, 8'd1);
    wr(8'h04, KEY, 16'h0400);
    rd(8'h04, v); chk("R6 cfg written", v, 32'h0400);
    wr(8'h1C, KEY, 16'h0001);
    wait_edges(8);  chk("R6 uncommitted no early", {31'b0, rst_req_o}, 0);
    wait_edges(1);  chk("R6 committed divisor timing", {31'b0, rst_req_o}, 1);
  endtask

  task automatic t_irq();
    do_reset();
    arm(16'd8, 8'd9);
    wr(8'h1C, KEY, 16'h0001);
    wait_edges(39); chk("R9 irq low", {31'b0, irq_o}, 0);
    wait_edges(1);  chk("R9 irq set", {31'b0, irq_o}, 1);
    wr(8'h18, KEY, 16'h0029);
    chk("R9 irq cleared", {31'b0, irq_o}, 0);
  endtask

  task automatic t_stop();
    do_reset();
    arm(16'd3, 8'd0);
    wr(8'h1C, KEY, 16'h0001);
    wr(8'h1C, KEY, 16'h0000);
    wait_edges(10); chk("R7 stopped no expiry", {31'b0, rst_req_o}, 0);
    wr(8'h1C, KEY, 16'h0001);
    wait_edges(2);  chk("R7 resume before zero", {31'b0, rst_req_o}, 0);
    wait_edges(1);  chk("R7 resume from held count", {31'b0, rst_req_o}, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * LIMIT);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #Q;
    t_reset();
    t_key();
    t_codes();
    t_expiry();
    t_reload();
    t_commit();
    t_irq();
    t_stop();
    finish_run();
  end
endmodule